// File: doc/BRIEF.md
# Sequential fractional multiply-divide unit

This block is the multiply, divide and double-word shift engine of an accumulator-style datapath. All values are W-bit two's-complement fractions: the top bit is the sign with weight 2^0 (0 for positive, 1 for negative), and the bits below it carry weights 2^-1 down to 2^-(W-1). Arithmetic wraps modulo 2. The surrounding datapath owns the accumulator (Ac) and the multiplier-quotient register (R). It passes their current values in with a start pulse, an operation code and a memory operand. It takes the new values back when `done` pulses.

Multiply takes the operand times R and returns the double-length signed product across Ac (high word) and R (low word). The product is computed one add-and-shift step per cycle, and the sign bit of R is handled by a subtracting final step. Divide returns the fractional quotient Ac / operand in R and the truncated remainder in Ac. It runs non-restoring on the magnitudes, one quotient bit per cycle, and applies a sign and remainder correction at the end. The two shift operations move the Ac:R pair left or right by one bit as a single 2W-bit word.

Two results cannot be represented and are flagged instead. A divide is flagged when the dividend is not strictly smaller in magnitude than the divisor. A multiply of the most negative value by itself is also flagged, because it would yield +1. A flagged operation returns Ac and R unchanged.

Top module: `mdu_unit`

## Requirements
- R1: With op = 2'b00 (multiply), a = operand and r = R taken as signed W-bit integers, the result satisfies {Ac,R} = 2·a·r as a 2W-bit word: Ac holds bits 2W-1..W and R holds bits W-1..0. ovf is 0.
- R2: A multiply whose operand and R are both the most negative value (sign bit 1, all other bits 0) sets ovf to 1 and returns Ac and R equal to the ac_in and r_in captured at start.
- R3: With op = 2'b01 (divide), N = Ac·2^(W-1) as a signed integer and d = operand, the result gives R = N/d truncated toward zero and Ac = N − R·d, so the remainder takes the sign of the dividend. ovf is 0.
- R4: A divide with |ac_in| ≥ |operand| (a zero operand included) sets ovf to 1 and returns Ac and R unchanged from the values captured at start.
- R5: op = 2'b10 shifts {Ac,R} left by one bit, with a 0 entering the lowest bit of R and the top bit of R moving into Ac. ovf is 0.
- R6: op = 2'b11 shifts {Ac,R} right by one bit arithmetically: the Ac sign bit is copied, and the lowest bit of Ac moves into the top bit of R. ovf is 0.
- R7: For a start accepted at clock edge E, done is high after edge E+W+1 for an unflagged multiply or divide. It is high after edge E+1 for a shift or a flagged operation.
- R8: done is high for exactly one cycle. ac_out, r_out and ovf change only together with done and hold their values until the next result.
- R9: A start seen while an operation is in progress is ignored and produces no extra result. A start in the cycle in which done is high is accepted.
- R10: While rst is high, and after it is released until the first result, done, ovf, ac_out and r_out are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 00 multiply, 01 divide, 10 shift left, 11 shift right |
| operand | input | W | Memory operand: multiplicand or divisor |
| ac_in | input | W | Current accumulator value |
| r_in | input | W | Current multiplier-quotient register value |
| ac_out | output | W | New accumulator value, valid from done |
| r_out | output | W | New multiplier-quotient value, valid from done |
| done | output | 1 | One-cycle result strobe |
| ovf | output | 1 | Result not representable; registers returned unchanged |

## Verification
The bench builds the unit with W = 16, so each multiply or divide takes 17 cycles. This allows several dozen random operand pairs per operation within a short run. The corner cases do not depend on the width and are all hit at this size: the most negative value on either input, dividend and divisor of equal magnitude, a zero divisor, and sign combinations that leave a negative remainder. The reference arithmetic in the bench is done on plain signed integers of more than twice the width, so the product and quotient expectations do not rely on the step-wise algorithms.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_DIV = 2'b01,
    OP_SHL = 2'b10,
    OP_SHR = 2'b11
  } mdu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV,
    ST_DFIX,
    ST_DONE
  } mdu_state_e;

endpackage

// File: rtl/mdu_mul_step.sv
// One add-and-arithmetic-shift step of a signed multiply.
// The last step subtracts the multiplicand because the multiplier's
// sign bit has negative weight.
module mdu_mul_step #(
  parameter int W = 40
) (
  input  logic [W:0]   hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] mcand_i,
  input  logic         last_i,
  output logic [W:0]   hi_o,
  output logic [W-1:0] lo_o
);
  logic [W:0] ext;
  logic [W:0] sum;

  always_comb begin
    ext = {mcand_i[W-1], mcand_i};
    if (lo_i[0])
      sum = last_i ? (hi_i - ext) : (hi_i + ext);
    else
      sum = hi_i;
    hi_o = {sum[W], sum[W:1]};
    lo_o = {sum[0], lo_i[W-1:1]};
  end
endmodule

// File: rtl/mdu_div_step.sv
// One non-restoring step on magnitudes: shift the partial remainder,
// then subtract or add the divisor according to its sign.
module mdu_div_step #(
  parameter int W = 40
) (
  input  logic [W+1:0] rem_i,
  input  logic [W:0]   dvs_i,
  output logic [W+1:0] rem_o,
  output logic         qbit_o
);
  localparam int RW = W + 2;
  logic [RW-1:0] sh;
  logic [RW-1:0] dx;

  always_comb begin
    sh     = {rem_i[RW-2:0], 1'b0};
    dx     = {1'b0, dvs_i};
    rem_o  = rem_i[RW-1] ? (sh + dx) : (sh - dx);
    qbit_o = ~rem_o[RW-1];
  end
endmodule

// File: rtl/mdu_div_fix.sv
// Final divide correction: restore a negative remainder, then give the
// quotient and remainder their signs.
module mdu_div_fix #(
  parameter int W = 40
) (
  input  logic [W+1:0] rem_i,
  input  logic [W:0]   dvs_i,
  input  logic [W-1:0] quo_i,
  input  logic         neg_q_i,
  input  logic         neg_r_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] r_o
);
  localparam int RW = W + 2;
  logic [W-1:0] rmag;

  always_comb begin
    rmag = W'(rem_i[RW-1] ? (rem_i + {1'b0, dvs_i}) : rem_i);
    ac_o = neg_r_i ? (~rmag + W'(1)) : rmag;
    r_o  = neg_q_i ? (~quo_i + W'(1)) : quo_i;
  end
endmodule

// File: rtl/mdu_dshift.sv
// One-bit shift of the Ac:R pair as a single double word.
module mdu_dshift #(
  parameter int W = 40
) (
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] r_i,
  input  logic         right_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] r_o
);
  always_comb begin
    if (right_i)
      {ac_o, r_o} = {ac_i[W-1], ac_i, r_i[W-1:1]};
    else
      {ac_o, r_o} = {ac_i[W-2:0], r_i, 1'b0};
  end
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] ac_in,
  input  logic [W-1:0] r_in,
  output logic [W-1:0] ac_out,
  output logic [W-1:0] r_out,
  output logic         done,
  output logic         ovf
);
  localparam int CW = $clog2(W + 1);
  localparam int RW = W + 2;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W:0] mag(input logic [W-1:0] v);
    logic [W:0] e;
    e = {v[W-1], v};
    return v[W-1] ? (~e + (W+1)'(1)) : e;
  endfunction

  mdu_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    hi_q;
  logic [W-1:0]  lo_q;
  logic [W-1:0]  mc_q;
  logic [RW-1:0] rem_q;
  logic [W:0]    dvs_q;
  logic [W-1:0]  quo_q;
  logic          neg_q_q;
  logic          neg_r_q;
  logic [W-1:0]  res_ac_q;
  logic [W-1:0]  res_r_q;
  logic          res_ovf_q;

  logic [W:0]    mul_hi;
  logic [W-1:0]  mul_lo;
  logic          mul_last;
  logic [RW-1:0] div_rem;
  logic          div_qb;
  logic [W-1:0]  fix_ac;
  logic [W-1:0]  fix_r;
  logic [W-1:0]  sh_ac;
  logic [W-1:0]  sh_r;
  logic          mul_ovf;
  logic          div_ovf;

  assign mul_last = (cnt_q == CW'(W - 1));
  assign mul_ovf  = (operand == MINV) && (r_in == MINV);
  assign div_ovf  = (mag(ac_in) >= mag(operand));

  mdu_mul_step #(.W(W)) u_mul_step (
    .hi_i    (hi_q),
    .lo_i    (lo_q),
    .mcand_i (mc_q),
    .last_i  (mul_last),
    .hi_o    (mul_hi),
    .lo_o    (mul_lo)
  );

  mdu_div_step #(.W(W)) u_div_step (
    .rem_i  (rem_q),
    .dvs_i  (dvs_q),
    .rem_o  (div_rem),
    .qbit_o (div_qb)
  );

  mdu_div_fix #(.W(W)) u_div_fix (
    .rem_i   (rem_q),
    .dvs_i   (dvs_q),
    .quo_i   (quo_q),
    .neg_q_i (neg_q_q),
    .neg_r_i (neg_r_q),
    .ac_o    (fix_ac),
    .r_o     (fix_r)
  );

  mdu_dshift #(.W(W)) u_dshift (
    .ac_i    (ac_in),
    .r_i     (r_in),
    .right_i (op[0]),
    .ac_o    (sh_ac),
    .r_o     (sh_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      mc_q      <= '0;
      rem_q     <= '0;
      dvs_q     <= '0;
      quo_q     <= '0;
      neg_q_q   <= 1'b0;
      neg_r_q   <= 1'b0;
      res_ac_q  <= '0;
      res_r_q   <= '0;
      res_ovf_q <= 1'b0;
      ac_out    <= '0;
      r_out     <= '0;
      ovf       <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            case (mdu_op_e'(op))
              OP_MUL: begin
                if (mul_ovf) begin
                  res_ac_q  <= ac_in;
                  res_r_q   <= r_in;
                  res_ovf_q <= 1'b1;
                  state_q   <= ST_DONE;
                end else begin
                  hi_q    <= '0;
                  lo_q    <= r_in;
                  mc_q    <= operand;
                  cnt_q   <= '0;
                  state_q <= ST_MUL;
                end
              end
              OP_DIV: begin
                if (div_ovf) begin
                  res_ac_q  <= ac_in;
                  res_r_q   <= r_in;
                  res_ovf_q <= 1'b1;
                  state_q   <= ST_DONE;
                end else begin
                  rem_q   <= RW'(mag(ac_in));
                  dvs_q   <= mag(operand);
                  quo_q   <= '0;
                  neg_q_q <= ac_in[W-1] ^ operand[W-1];
                  neg_r_q <= ac_in[W-1];
                  cnt_q   <= '0;
                  state_q <= ST_DIV;
                end
              end
              default: begin
                res_ac_q  <= sh_ac;
                res_r_q   <= sh_r;
                res_ovf_q <= 1'b0;
                state_q   <= ST_DONE;
              end
            endcase
          end
        end
        ST_MUL: begin
          hi_q  <= mul_hi;
          lo_q  <= mul_lo;
          cnt_q <= cnt_q + CW'(1);
          if (mul_last) begin
            res_ac_q  <= {mul_hi[W-2:0], mul_lo[W-1]};
            res_r_q   <= {mul_lo[W-2:0], 1'b0};
            res_ovf_q <= 1'b0;
            state_q   <= ST_DONE;
          end
        end
        ST_DIV: begin
          rem_q <= div_rem;
          quo_q <= {quo_q[W-2:0], div_qb};
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(W - 2))
            state_q <= ST_DFIX;
        end
        ST_DFIX: begin
          res_ac_q  <= fix_ac;
          res_r_q   <= fix_r;
          res_ovf_q <= 1'b0;
          state_q   <= ST_DONE;
        end
        ST_DONE: begin
          ac_out  <= res_ac_q;
          r_out   <= res_r_q;
          ovf     <= res_ovf_q;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] ac_in,
  input logic [W-1:0] r_in,
  input logic [W-1:0] ac_out,
  input logic [W-1:0] r_out,
  input logic         done,
  input logic         ovf
);
  localparam int LW = $clog2(W + 2) + 1;

  logic          busy_q;
  logic [LW-1:0] lat_q;
  logic [W-1:0]  cap_ac;
  logic [W-1:0]  cap_r;
  logic [1:0]    cap_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      lat_q  <= '0;
      cap_ac <= '0;
      cap_r  <= '0;
      cap_op <= '0;
    end else if (start && (!busy_q || done)) begin
      busy_q <= 1'b1;
      lat_q  <= '0;
      cap_ac <= ac_in;
      cap_r  <= r_in;
      cap_op <= op;
    end else begin
      if (done)   busy_q <= 1'b0;
      if (busy_q) lat_q  <= lat_q + LW'(1);
    end
  end

  // R8: one-cycle strobe
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: results held between strobes
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(ac_out) && $stable(r_out) && $stable(ovf)));

  // R7 and R9: every strobe answers an accepted start, at one of two latencies
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_q && ((lat_q == LW'(1)) || (lat_q == LW'(W + 1)))));

  // R4 and R2: flagged results return the captured registers
  p_ovf_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (done && ovf) |-> ((ac_out == cap_ac) && (r_out == cap_r)));

  p_shl_r5: assert property (@(posedge clk) disable iff (rst)
    (done && cap_op == 2'b10) |-> (!ovf && ({ac_out, r_out} == {cap_ac[W-2:0], cap_r, 1'b0})));

  p_shr_r6: assert property (@(posedge clk) disable iff (rst)
    (done && cap_op == 2'b11) |-> (!ovf && ({ac_out, r_out} == {cap_ac[W-1], cap_ac, cap_r[W-1:1]})));

  // R2: the flag on multiply appears only for the one unrepresentable product
  p_mul_ovf_r2: assert property (@(posedge clk) disable iff (rst)
    (done && ovf && cap_op == 2'b00) |-> (cap_r == {1'b1, {(W-1){1'b0}}}));
endmodule

bind mdu_unit mdu_checker #(.W(W)) u_mdu_checker (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op     (op),
  .ac_in  (ac_in),
  .r_in   (r_in),
  .ac_out (ac_out),
  .r_out  (r_out),
  .done   (done),
  .ovf    (ovf)
);

// File: tb/test_mdu_unit.sv
module test_mdu_unit;
  localparam int W  = 16;
  localparam int XW = 2 * W + 4;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  typedef struct {
    logic [W-1:0] ac;
    logic [W-1:0] r;
    logic         ovf;
    int           lat;
    int           t0;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   op = 2'b00;
  logic [W-1:0] operand = '0;
  logic [W-1:0] ac_in = '0;
  logic [W-1:0] r_in = '0;
  logic [W-1:0] ac_out;
  logic [W-1:0] r_out;
  logic         done;
  logic         ovf;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];
  exp_t last;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdu_unit #(.W(W)) i_mdu_unit (
    .clk(clk), .rst(rst), .start(start), .op(op), .operand(operand),
    .ac_in(ac_in), .r_in(r_in), .ac_out(ac_out), .r_out(r_out),
    .done(done), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic exp_t model(input logic [1:0] o, input logic [W-1:0] m,
                                 input logic [W-1:0] a, input logic [W-1:0] rr);
    exp_t e;
    logic signed [XW-1:0] sm, sa, sr, p, n, q, rm, am, aa;
    sm = {{(XW-W){m[W-1]}}, m};
    sa = {{(XW-W){a[W-1]}}, a};
    sr = {{(XW-W){rr[W-1]}}, rr};
    e.ac = a; e.r = rr; e.ovf = 1'b0; e.lat = 1; e.t0 = 0; e.req = "";
    case (o)
      2'b00: begin
        if (m == MINV && rr == MINV) e.ovf = 1'b1;
        else begin
          p = (sm * sr) <<< 1;
          e.ac = p[2*W-1:W]; e.r = p[W-1:0]; e.lat = W + 1;
        end
      end
      2'b01: begin
        aa = (sa < 0) ? -sa : sa;
        am = (sm < 0) ? -sm : sm;
        if (aa >= am) e.ovf = 1'b1;
        else begin
          n  = sa <<< (W - 1);
          q  = n / sm;
          rm = n - q * sm;
          e.ac = rm[W-1:0]; e.r = q[W-1:0]; e.lat = W + 1;
        end
      end
      2'b10: {e.ac, e.r} = {a, rr} << 1;
      default: {e.ac, e.r} = {a[W-1], a, rr[W-1:1]};
    endcase
    return e;
  endfunction

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", 64'(ac_out), 64'(0));
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(ac_out == e.ac, e.req, "ac_out", 64'(ac_out), 64'(e.ac));
        chk(r_out == e.r, e.req, "r_out", 64'(r_out), 64'(e.r));
        chk(ovf == e.ovf, e.req, "ovf", 64'(ovf), 64'(e.ovf));
        chk((cyc - e.t0 - 1) == e.lat, "R7", "latency",
            64'(cyc - e.t0 - 1), 64'(e.lat));
      end
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [W-1:0] m,
                        input logic [W-1:0] a, input logic [W-1:0] rr,
                        input string req);
    exp_t e;
    e = model(o, m, a, rr);
    e.req = req;
    @(negedge clk);
    e.t0 = cyc;
    sb.push_back(e);
    start = 1'b1; op = o; operand = m; ac_in = a; r_in = rr;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    last = e;
  endtask

  task automatic hold_check;
    repeat (3) @(negedge clk);
    chk(ac_out == last.ac && r_out == last.r && ovf == last.ovf && !done,
        "R8", "held result", 64'({ac_out, r_out}), 64'({last.ac, last.r}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && ovf == 1'b0, "R10", "flags in reset", 64'({done, ovf}), 64'(0));
    chk(ac_out == '0 && r_out == '0, "R10", "data in reset", 64'({ac_out, r_out}), 64'(0));
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && ac_out == '0 && r_out == '0, "R10", "idle after reset",
        64'({ac_out, r_out}), 64'(0));

    // R1: multiply
    run_op(2'b00, 16'h4000, 16'h1234, 16'h4000, "R1");
    hold_check();
    run_op(2'b00, 16'hC000, 16'h0000, 16'h4000, "R1");
    run_op(2'b00, MINV, 16'h0000, 16'h4000, "R1");
    run_op(2'b00, MINV, 16'h0000, 16'h0001, "R1");
    run_op(2'b00, 16'h7FFF, 16'h0000, MINV, "R1");
    run_op(2'b00, 16'hFFFF, 16'h0000, 16'hFFFF, "R1");
    run_op(2'b00, 16'h0000, 16'h5555, 16'h7FFF, "R1");
    for (int i = 0; i < 40; i++)
      run_op(2'b00, W'($urandom), W'($urandom), W'($urandom), "R1");

    // R2: -1 times -1
    run_op(2'b00, MINV, 16'h2468, MINV, "R2");
    hold_check();

    // R3: divide
    run_op(2'b01, 16'h4000, 16'h2000, 16'h0000, "R3");
    run_op(2'b01, 16'hC000, 16'h2000, 16'h1111, "R3");
    run_op(2'b01, 16'h3000, 16'hE000, 16'h0000, "R3");
    run_op(2'b01, 16'hD000, 16'hE001, 16'h0000, "R3");
    run_op(2'b01, MINV, 16'h7FFF, 16'h0000, "R3");
    run_op(2'b01, 16'h7FFF, 16'h7FFE, 16'h0000, "R3");
    run_op(2'b01, 16'h0003, 16'h0001, 16'h0000, "R3");
    for (int i = 0; i < 40; i++)
      run_op(2'b01, W'($urandom), W'($urandom) >> ($urandom % 8), W'($urandom), "R3");

    // R4: divide overflow
    run_op(2'b01, 16'h2000, 16'h2000, 16'h5A5A, "R4");
    run_op(2'b01, 16'h2000, 16'hE000, 16'h0F0F, "R4");
    run_op(2'b01, 16'h0000, 16'h0000, 16'h1357, "R4");
    run_op(2'b01, 16'h1000, MINV, 16'h0001, "R4");
    hold_check();

    // R5, R6: double-word shifts
    run_op(2'b10, 16'h0000, 16'h4001, 16'h8001, "R5");
    run_op(2'b10, 16'hFFFF, 16'hFFFF, 16'h7FFF, "R5");
    run_op(2'b11, 16'h0000, 16'h8003, 16'h0002, "R6");
    run_op(2'b11, 16'h0000, 16'h4001, 16'hFFFF, "R6");

    // R9: start while busy is ignored; start on the strobe cycle is accepted
    begin
      exp_t e;
      e = model(2'b00, 16'h3000, 16'h0000, 16'h5000);
      e.req = "R9";
      @(negedge clk);
      e.t0 = cyc;
      sb.push_back(e);
      start = 1'b1; op = 2'b00; operand = 16'h3000; ac_in = 16'h0000; r_in = 16'h5000;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1; op = 2'b10; ac_in = 16'hFFFF; r_in = 16'hFFFF;
      @(negedge clk);
      start = 1'b0;
      ac_in = 16'h1111; r_in = 16'h2222; operand = 16'h7777;
      while (!done) @(negedge clk);
      // done is high now: start in this cycle must be taken
      e = model(2'b11, 16'h0000, 16'h8888, 16'h0001);
      e.req = "R9";
      e.t0 = cyc;
      sb.push_back(e);
      start = 1'b1; op = 2'b11; ac_in = 16'h8888; r_in = 16'h0001;
      @(negedge clk);
      start = 1'b0;
      while (sb.size() != 0) @(negedge clk);
      repeat (W + 4) @(negedge clk);
    end

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule